// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block lets a host drive a three-wire serial EEPROM by toggling bits in a single control register. The EEPROM's select, clock and data lines are shared with an external memory port. The host asks for the lines by setting a request bit. The arbiter then waits until the memory port reports that it is idle. At that point it takes the lines, drives the EEPROM pins from the register bits, and shows a ready flag.

Once the lines are held, the ready flag also acts as a pacing timer. Every register write that keeps the request set clears ready. Ready then returns after a fixed delay, given as a count of clock cycles derived from a delay in nanoseconds and the clock period. The host therefore bit-bangs the EEPROM protocol by writing the register, polling ready, and writing again.

Clearing the request bit hands the lines back to the memory port and drives the EEPROM pins low. The EEPROM output pin is synchronised and can be read back while access is held.

Top module: `eeprom_port_arb`

## Requirements
- R1: After reset `portGrant`, `romCs`, `romClk`, `romDout` and every bit of `regRdData` are 0.
- R2: Register layout. Bit 5 is request (written and read back), bit 4 is ready (read only), bit 3 is chip select, bit 2 is serial clock, bit 1 is data out (these three are written and read back), and bit 0 is data in (read only). Bits 7:6 read 0. Written values show on `regRdData` from the cycle after the write edge.
- R3: `portGrant` rises at the first clock edge at which the request bit is already stored and `memBusy` is low. Ready reads 1 in that same cycle, with no pacing delay.
- R4: No grant is given while `memBusy` is high. Once the grant is held, `memBusy` has no effect on it.
- R5: `romCs`, `romClk` and `romDout` follow register bits 3, 2 and 1 only while `portGrant` is high. At all other times they are 0.
- R6: A write with bit 5 = 1 while the grant is already held makes ready read 0 for exactly DELAY_CYC cycles after the write edge. DELAY_CYC = ceil(DELAY_NS / CLK_PERIOD_NS), which is 80 with the defaults. Ready then reads 1. A further write restarts the full delay.
- R7: A write with bit 5 = 0 drops `portGrant` and drives all EEPROM pins to 0 from the next cycle. Ready reads 0 after that.
- R8: While the grant is held, bit 0 reads `romDin` delayed by two clock edges. Without the grant, bit 0 reads 0.
- R9: Writes made before the grant start no pacing delay. A write that lands on the grant edge itself leaves ready at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register read value |
| memBusy | input | 1 | External memory port is serving another request |
| portGrant | output | 1 | Shared lines currently held for the EEPROM |
| romCs | output | 1 | EEPROM chip select |
| romClk | output | 1 | EEPROM serial clock |
| romDout | output | 1 | Data to the EEPROM |
| romDin | input | 1 | Data from the EEPROM |

## Verification
Register bits, pin levels and the grant take effect one clock edge after the write or after `memBusy` falls. Ready returns exactly DELAY_CYC edges after a paced write. Data in appears two edges after the pin changes. A behavioural model in the bench advances on each rising edge from the same inputs. Its results are compared with the outputs on every falling edge, so each check samples after the edge that is due to change the value. Directed checks also count the falling edges spent with ready low after each paced write, and look at the exact cycle of the grant and of the data-in change.

// File: rtl/eeprom_arb_pkg.sv
package eeprom_arb_pkg;
  localparam int REG_W    = 8;
  localparam int REQ_BIT  = 5;
  localparam int RDY_BIT  = 4;
  localparam int CS_BIT   = 3;
  localparam int CLK_BIT  = 2;
  localparam int DOUT_BIT = 1;
  localparam int DIN_BIT  = 0;

  typedef struct packed {
    logic grant;
    logic ready;
  } arbStrobe_t;
endpackage

// File: rtl/eeprom_arb_ctrl.sv
module eeprom_arb_ctrl
  import eeprom_arb_pkg::*;
#(
  parameter int DELAY_CYC = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       regWrEn,
  input  logic       wrReq,
  input  logic       reqHeld,
  input  logic       memBusy,
  output arbStrobe_t strobe
);
  localparam int CNT_W = $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYC);

  logic             grantQ;
  logic [CNT_W-1:0] paceCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grantQ  <= 1'b0;
      paceCnt <= '0;
    end else if (regWrEn && !wrReq) begin
      // release: hand lines back to the memory port
      grantQ  <= 1'b0;
      paceCnt <= '0;
    end else begin
      if (reqHeld && !grantQ && !memBusy)
        grantQ <= 1'b1;
      if (regWrEn && grantQ)
        paceCnt <= CNT_LOAD;
      else if (paceCnt != '0)
        paceCnt <= paceCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.grant = grantQ;
    strobe.ready = grantQ && (paceCnt == '0);
  end
endmodule

// File: rtl/eeprom_arb_dp.sv
module eeprom_arb_dp
  import eeprom_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  arbStrobe_t       strobe,
  input  logic             romDin,
  output logic             reqHeld,
  output logic             romCs,
  output logic             romClk,
  output logic             romDout,
  output logic [REG_W-1:0] regRdData
);
  logic                   reqQ;
  logic                   csQ, clkQ, doutQ;
  logic [SYNC_STAGES-1:0] dinSync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqQ  <= 1'b0;
      csQ   <= 1'b0;
      clkQ  <= 1'b0;
      doutQ <= 1'b0;
    end else if (regWrEn) begin
      reqQ  <= regWrData[REQ_BIT];
      csQ   <= regWrData[CS_BIT];
      clkQ  <= regWrData[CLK_BIT];
      doutQ <= regWrData[DOUT_BIT];
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) dinSync <= '0;
        else        dinSync <= romDin;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rst_n) dinSync <= '0;
        else        dinSync <= {dinSync[SYNC_STAGES-2:0], romDin};
      end
    end
  endgenerate

  assign reqHeld = reqQ;
  assign romCs   = strobe.grant & csQ;
  assign romClk  = strobe.grant & clkQ;
  assign romDout = strobe.grant & doutQ;

  always_comb begin
    regRdData           = '0;
    regRdData[REQ_BIT]  = reqQ;
    regRdData[RDY_BIT]  = strobe.ready;
    regRdData[CS_BIT]   = csQ;
    regRdData[CLK_BIT]  = clkQ;
    regRdData[DOUT_BIT] = doutQ;
    regRdData[DIN_BIT]  = strobe.grant & dinSync[SYNC_STAGES-1];
  end
endmodule

// File: rtl/eeprom_port_arb.sv
module eeprom_port_arb
  import eeprom_arb_pkg::*;
#(
  parameter int DELAY_NS      = 800,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       memBusy,
  output logic       portGrant,
  output logic       romCs,
  output logic       romClk,
  output logic       romDout,
  input  logic       romDin
);
  localparam int DELAY_CYC = (DELAY_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  arbStrobe_t strobe;
  logic       reqHeld;

  eeprom_arb_ctrl #(.DELAY_CYC(DELAY_CYC)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regWrEn (regWrEn),
    .wrReq   (regWrData[REQ_BIT]),
    .reqHeld (reqHeld),
    .memBusy (memBusy),
    .strobe  (strobe)
  );

  eeprom_arb_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobe    (strobe),
    .romDin    (romDin),
    .reqHeld   (reqHeld),
    .romCs     (romCs),
    .romClk    (romClk),
    .romDout   (romDout),
    .regRdData (regRdData)
  );

  assign portGrant = strobe.grant;
endmodule

// File: rtl/eeprom_arb_chk.sv
module eeprom_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       memBusy,
  input logic       portGrant,
  input logic       romCs,
  input logic       romClk,
  input logic       romDout,
  input logic       romDin
);
  // R4: a new grant only follows an idle memory port
  a_r4_grant_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(portGrant) |-> $past(!memBusy));

  // R3: ready reads 1 together with the grant
  a_r3_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(portGrant) |-> regRdData[4]);

  // R5: pins idle without the grant
  a_r5_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !portGrant |-> (!romCs && !romClk && !romDout));

  // R6: a paced write clears ready
  a_r6_write_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regWrData[5] && portGrant) |=> !regRdData[4]);

  // R6: ready only falls on a write
  a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdData[4] && !regWrEn) |=> regRdData[4]);

  // R7: clearing the request releases the lines
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && !regWrData[5]) |=> (!portGrant && !regRdData[4]));

  // R2: upper bits always read 0
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    regRdData[7:6] == 2'b00);
endmodule

bind eeprom_port_arb eeprom_arb_chk u_chk (.*);

// File: tb/sim_eeprom_port_arb.sv
`timescale 1ns/1ps
module sim_eeprom_port_arb;
  localparam int DLY = (800 + 10 - 1) / 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       memBusy = 1'b0;
  logic       portGrant, romCs, romClk, romDout;
  logic       romDin = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit modelOn = 1'b0;

  eeprom_port_arb u0 (.*);

  always #5 clk = ~clk;

  // behavioural reference model
  bit mReq, mGrant, mCs, mClk, mDout, s1, s2;
  int mCnt;

  always @(posedge clk) begin
    bit oldReq, oldGrant;
    cycles++;
    if (!rst_n) begin
      mReq = 0; mGrant = 0; mCs = 0; mClk = 0; mDout = 0; s1 = 0; s2 = 0; mCnt = 0;
    end else begin
      oldReq = mReq; oldGrant = mGrant;
      s2 = s1; s1 = romDin;
      if (regWrEn && !regWrData[5]) begin
        mGrant = 0; mCnt = 0;
      end else begin
        if (oldReq && !oldGrant && !memBusy) mGrant = 1;
        if (regWrEn && oldGrant) mCnt = DLY;
        else if (mCnt > 0) mCnt--;
      end
      if (regWrEn) begin
        mReq = regWrData[5]; mCs = regWrData[3]; mClk = regWrData[2]; mDout = regWrData[1];
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn) begin
      bit rdy;
      rdy = mGrant && (mCnt == 0);
      chk("R3", "grant", portGrant, mGrant);
      chk("R5", "pins", {romCs, romClk, romDout}, {mGrant & mCs, mGrant & mClk, mGrant & mDout});
      chk("R6", "ready", regRdData[4], rdy);
      chk("R2", "readback", regRdData,
          {2'b00, mReq, rdy, mCs, mClk, mDout, mGrant & s2});
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic measureLow(string req);
    int low = 0;
    while (!regRdData[4] && low < 1000) begin
      low++;
      @(negedge clk);
    end
    chk(req, "ready low cycles", low, DLY);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset rd", regRdData, 0);
    chk("R1", "reset grant/pins", {portGrant, romCs, romClk, romDout}, 0);
    rst_n = 1'b1;
    modelOn = 1'b1;

    // R4: busy blocks grant; R9: early write starts no delay
    memBusy = 1'b1;
    wr(8'h2E);
    repeat (4) @(negedge clk);
    chk("R4", "no grant while busy", portGrant, 0);
    chk("R5", "pins idle before grant", {romCs, romClk, romDout}, 0);
    chk("R2", "stored bits", regRdData, 8'h2E);

    // R3: grant one edge after busy falls, ready at once
    memBusy = 1'b0;
    @(negedge clk);
    chk("R3", "grant after idle", portGrant, 1);
    chk("R9", "ready with grant", regRdData[4], 1);
    chk("R5", "pins driven", {romCs, romClk, romDout}, 3'b111);

    // R4: busy ignored after grant
    memBusy = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4", "grant kept while busy", portGrant, 1);

    // R6: paced write
    wr(8'h24);
    chk("R5", "pins follow write", {romCs, romClk, romDout}, 3'b010);
    measureLow("R6");

    // R6: restart by a second write
    wr(8'h2A);
    repeat (30) @(negedge clk);
    chk("R6", "still low mid-delay", regRdData[4], 0);
    wr(8'h28);
    measureLow("R6");

    // R8: data in via two-stage sync
    romDin = 1'b1;
    @(negedge clk);
    chk("R8", "din after one edge", regRdData[0], 0);
    @(negedge clk);
    chk("R8", "din after two edges", regRdData[0], 1);

    // R7: release
    wr(8'h0E);
    chk("R7", "grant dropped", portGrant, 0);
    chk("R7", "pins zero", {romCs, romClk, romDout}, 0);
    chk("R7", "ready zero", regRdData[4], 0);
    chk("R8", "din hidden without grant", regRdData[0], 0);

    // R3: request with idle port grants one edge after the write
    memBusy = 1'b0;
    wr(8'h20);
    chk("R3", "not yet granted", portGrant, 0);
    @(negedge clk);
    chk("R3", "granted next edge", portGrant, 1);
    chk("R3", "ready with grant", regRdData[4], 1);
    romDin = 1'b0;
    wr(8'h2C);
    measureLow("R6");
    wr(8'h00);
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule